// File: doc/BRIEF.md
# Capture/Reload Timer with Up-Down Mode

This block is a 16-bit timer that can also work as an event counter. In timer function it advances once per machine-cycle tick. In counter function it advances on a falling edge of an external count pin, which is sampled once per tick. A second external pin, the trigger pin, does one of three jobs, chosen by the mode. It can be a capture strobe that copies the count into a 16-bit register pair. It can be a reload strobe that loads the count from that same pair. In up/down mode its level sets the counting direction.

Software sets the block up through a small addressed byte bus. There is a control register, a mode register, the two count bytes and the two reload/capture bytes. The block has a combined interrupt request output. It also has a one-cycle wrap pulse, which a serial port can use as its bit-rate clock. When either serial-clock select bit is set, the block runs as a free-running reload generator and raises no flags.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the control register, mode register, count and reload pair all read 0, and `irq` and `ovfPulse` are 0.
- R2: Bus map (byte addresses). 0 is control, 1 is mode (bit 0 is down-count enable), 2/3 are count low/high, 4/5 are reload low/high. Unused addresses read 0. Control bits: 0 run, 1 counter select, 2 capture select, 3 external enable, 4 receive-clock select, 5 transmit-clock select, 6 external flag, 7 overflow flag. Written values read back.
- R3: In timer function with run set, the count advances by one per `machineTick`. With run clear it holds.
- R4: In counter function, `cntPin` is sampled on each tick. The count advances only on a tick whose sample is low when the previous sample was high.
- R5: In capture mode (both serial-clock bits clear, capture select set), a sampled falling edge on `trigPin` with external enable set copies the count into the reload pair and sets the external flag. An overflow wraps the count to 0000h and sets the overflow flag.
- R6: In auto-reload mode (capture select clear, down-count enable clear), an overflow past FFFFh loads the count from the reload pair and sets the overflow flag. A sampled falling edge on `trigPin` with external enable set also loads the count and sets the external flag.
- R7: In up/down mode (auto-reload with down-count enable set), a high `trigPin` counts up and a low one counts down. Counting down when the count equals the reload pair loads FFFFh and sets the overflow flag. Every overflow or underflow toggles the external flag.
- R8: With either serial-clock bit set, capture select and the trigger pin are ignored, the count reloads on overflow, and no flag is set.
- R9: With external enable clear, trigger-pin edges change neither the count, the reload pair nor the external flag.
- R10: Flags are cleared only by a software write to the control register. Once set, they stay set across later counting.
- R11: `irq` is the overflow flag OR the external flag. The external flag is masked out in up/down mode.
- R12: `ovfPulse` is high for exactly one cycle after each overflow or underflow, in every mode.
- R13: A software write to a count byte in the same cycle as a tick replaces the count step. The written value stands, and counting resumes on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| machineTick | input | 1 | One-cycle pulse per machine cycle |
| cntPin | input | 1 | External event input for counter function |
| trigPin | input | 1 | Capture/reload strobe or direction input |
| wrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `busAddr` (combinational) |
| irq | output | 1 | Combined interrupt request |
| ovfPulse | output | 1 | One-cycle pulse on each overflow or underflow |

## Verification
The bench builds the block with the default widths: a 16-bit count and a 3-bit address. Because the count can be preset through the bus to a value just below FFFFh, or just above the reload value, every wrap, reload and underflow case is reached within a few ticks. Short sequences of pin levels, held across ticks, give the high-then-low sample pairs that drive capture, reload, counting and direction.

// File: rtl/crt_pkg.sv
package crt_pkg;
  // control register bit positions
  localparam int RUN_B    = 0;
  localparam int CTR_B    = 1;
  localparam int CAP_B    = 2;
  localparam int EXT_EN_B = 3;
  localparam int RX_B     = 4;
  localparam int TX_B     = 5;
  localparam int EXT_F_B  = 6;
  localparam int OVF_F_B  = 7;
  // fixed register addresses
  localparam int CTRL_ADDR = 0;
  localparam int MODE_ADDR = 1;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic loadReload;
    logic loadOnes;
    logic loadCapture;
  } crtStrobe_t;
endpackage

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CNT_BASE = 2,
  parameter int BYTES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              machineTick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              cntAtMax,
  input  logic              cntAtReload,
  output crtStrobe_t        strobe,
  output logic [7:0]        ctrlReg,
  output logic              downEn,
  output logic              irq,
  output logic              ovfPulse
);
  localparam logic [ADDR_W-1:0] CNT_LO = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HI = ADDR_W'(CNT_BASE + BYTES - 1);

  logic [7:0] ctrlQ, ctrlNext;
  logic downEnQ, cntSampQ, trigSampQ, ovfPulseQ;
  logic baudMode, capMode, upDownMode, ctrlWr, cntWr;
  logic cntFall, trigFall, step, dirDown, goUp, goDown, wrapUp, wrapDown, anyWrap;

  // mode decode
  assign baudMode   = ctrlQ[RX_B] | ctrlQ[TX_B];
  assign capMode    = ~baudMode & ctrlQ[CAP_B];
  assign upDownMode = ~baudMode & ~ctrlQ[CAP_B] & downEnQ;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign cntWr  = wrEn && (wrAddr >= CNT_LO) && (wrAddr <= CNT_HI);

  // per-tick edge detection on the sampled pins
  assign cntFall  = machineTick & cntSampQ & ~cntPin;
  assign trigFall = machineTick & trigSampQ & ~trigPin & ctrlQ[EXT_EN_B]
                    & ~baudMode & ~upDownMode;

  assign step     = ctrlQ[RUN_B] & ~cntWr & (ctrlQ[CTR_B] ? cntFall : machineTick);
  assign dirDown  = upDownMode & ~trigPin;
  assign goUp     = step & ~dirDown;
  assign goDown   = step & dirDown;
  assign wrapUp   = goUp & cntAtMax;
  assign wrapDown = goDown & cntAtReload;
  assign anyWrap  = wrapUp | wrapDown;

  always_comb begin
    strobe.stepUp      = goUp;
    strobe.stepDown    = goDown;
    strobe.loadReload  = ~cntWr & ~capMode & (wrapUp | trigFall);
    strobe.loadOnes    = wrapDown;
    strobe.loadCapture = trigFall & capMode;
  end

  // flags: hardware events are applied on top of a software write
  always_comb begin
    ctrlNext = ctrlQ;
    if (ctrlWr) ctrlNext = wrData;
    if (anyWrap && !baudMode) ctrlNext[OVF_F_B] = 1'b1;
    if (trigFall) ctrlNext[EXT_F_B] = 1'b1;
    if (anyWrap && upDownMode) ctrlNext[EXT_F_B] = ~ctrlNext[EXT_F_B];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      downEnQ   <= 1'b0;
      cntSampQ  <= 1'b0;
      trigSampQ <= 1'b0;
      ovfPulseQ <= 1'b0;
    end else begin
      ctrlQ <= ctrlNext;
      if (wrEn && (wrAddr == ADDR_W'(MODE_ADDR))) downEnQ <= wrData[0];
      if (machineTick) begin
        cntSampQ  <= cntPin;
        trigSampQ <= trigPin;
      end
      ovfPulseQ <= anyWrap;
    end
  end

  assign ctrlReg  = ctrlQ;
  assign downEn   = downEnQ;
  assign ovfPulse = ovfPulseQ;
  assign irq      = ctrlQ[OVF_F_B] | (ctrlQ[EXT_F_B] & ~upDownMode);

  // R12
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulseQ |-> (ctrlQ[OVF_F_B] || $past(baudMode)));
  // R9
  trig_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[EXT_EN_B] && !upDownMode && !ctrlWr) |=> !$rose(ctrlQ[EXT_F_B]));
  // R8
  baud_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baudMode && !ctrlWr && !ctrlQ[OVF_F_B]) |=> !ctrlQ[OVF_F_B]);
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import crt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CNT_BASE = 2,
  parameter int RLD_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  crtStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              cntAtMax,
  output logic              cntAtReload
);
  localparam int BYTES = CNT_W / 8;

  logic [CNT_W-1:0] cntQ, cntNext, rldQ, rldNext;
  logic [BYTES-1:0] rldByteWr;

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_rldWr
      assign rldByteWr[g] = wrEn && (busAddr == ADDR_W'(RLD_BASE + g));
    end
  endgenerate

  always_comb begin
    cntNext = cntQ;
    rldNext = rldQ;
    if (strobe.loadReload)    cntNext = rldQ;
    else if (strobe.loadOnes) cntNext = '1;
    else if (strobe.stepUp)   cntNext = cntQ + 1'b1;
    else if (strobe.stepDown) cntNext = cntQ - 1'b1;
    if (strobe.loadCapture) rldNext = cntQ;
    for (int i = 0; i < BYTES; i++) begin
      if (wrEn && (busAddr == ADDR_W'(CNT_BASE + i))) cntNext[i*8 +: 8] = wrData;
      if (rldByteWr[i]) rldNext[i*8 +: 8] = wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      rldQ <= '0;
    end else begin
      cntQ <= cntNext;
      rldQ <= rldNext;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (busAddr == ADDR_W'(CNT_BASE + i)) rdData = cntQ[i*8 +: 8];
      if (busAddr == ADDR_W'(RLD_BASE + i)) rdData = rldQ[i*8 +: 8];
    end
  end

  assign cntAtMax    = &cntQ;
  assign cntAtReload = (cntQ == rldQ);

  // R7
  ones_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOnes |=> (cntQ == '1));
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCapture && (rldByteWr == '0)) |=> (rldQ == $past(cntQ)));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp && !strobe.loadReload) |=> (cntQ == CNT_W'($past(cntQ) + 1'b1)));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              machineTick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq,
  output logic              ovfPulse
);
  localparam int BYTES    = CNT_W / 8;
  localparam int CNT_BASE = MODE_ADDR + 1;
  localparam int RLD_BASE = CNT_BASE + BYTES;

  crtStrobe_t strobe;
  logic [7:0] ctrlReg, dpRd;
  logic downEn, cntAtMax, cntAtReload;

  crt_ctrl #(.ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE), .BYTES(BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .machineTick(machineTick), .cntPin(cntPin),
    .trigPin(trigPin), .wrEn(wrEn), .wrAddr(busAddr), .wrData(wrData),
    .cntAtMax(cntAtMax), .cntAtReload(cntAtReload), .strobe(strobe),
    .ctrlReg(ctrlReg), .downEn(downEn), .irq(irq), .ovfPulse(ovfPulse)
  );

  crt_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE),
                 .RLD_BASE(RLD_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .busAddr(busAddr),
    .wrData(wrData), .rdData(dpRd), .cntAtMax(cntAtMax), .cntAtReload(cntAtReload)
  );

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_ADDR))      rdData = ctrlReg;
    else if (busAddr == ADDR_W'(MODE_ADDR)) rdData = {7'b0, downEn};
    else                                    rdData = dpRd;
  end
endmodule

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic machineTick = 1'b0, cntPin = 1'b0, trigPin = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irq, ovfPulse;

  always #2.5 clk = ~clk;

  cap_reload_timer #(.CNT_W(16), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .machineTick(machineTick), .cntPin(cntPin),
    .trigPin(trigPin), .wrEn(wrEn), .busAddr(busAddr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .ovfPulse(ovfPulse)
  );

  typedef struct {
    string      tag;
    int         kind;   // 0 read data, 1 irq, 2 wrap pulse
    logic [7:0] exp;
  } expItem_t;

  expItem_t expQ[$];
  event chkEv;
  int checks = 0, failures = 0;
  bit finished = 0;

  // monitor: pops expected items and compares them with the outputs
  initial begin : monitor
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0:       act = rdData;
          1:       act = {7'b0, irq};
          default: act = {7'b0, ovfPulse};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic pushExp(int kind, logic [7:0] e, string tag);
    expItem_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    expQ.push_back(it);
    ->chkEv;
    #0.1;
  endtask

  task automatic expRd(logic [ADDR_W-1:0] a, logic [7:0] e, string tag);
    busAddr = a;
    #0.1;
    pushExp(0, e, tag);
  endtask

  task automatic expCnt(logic [15:0] e, string tag);
    expRd(3'd2, e[7:0], {tag, " cntLo"});
    expRd(3'd3, e[15:8], {tag, " cntHi"});
  endtask

  task automatic expRld(logic [15:0] e, string tag);
    expRd(3'd4, e[7:0], {tag, " rldLo"});
    expRd(3'd5, e[15:8], {tag, " rldHi"});
  endtask

  task automatic wrReg(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; busAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrCnt(logic [15:0] v);
    wrReg(3'd2, v[7:0]);
    wrReg(3'd3, v[15:8]);
  endtask

  task automatic wrRld(logic [15:0] v);
    wrReg(3'd4, v[7:0]);
    wrReg(3'd5, v[15:8]);
  endtask

  task automatic doTick;
    @(negedge clk);
    machineTick = 1'b1;
    @(negedge clk);
    machineTick = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expRd(3'd0, 8'h00, "R1 ctrl");
    expRd(3'd1, 8'h00, "R1 mode");
    expCnt(16'h0000, "R1");
    expRld(16'h0000, "R1");
    pushExp(1, 8'h00, "R1 irq");
    pushExp(2, 8'h00, "R1 pulse");

    // R2 register access
    wrRld(16'h1234);
    wrCnt(16'hFFFD);
    expRld(16'h1234, "R2");
    expCnt(16'hFFFD, "R2");
    expRd(3'd6, 8'h00, "R2 unused");

    // R3 timer stepping, run gating
    wrReg(3'd0, 8'h01);
    doTick; doTick;
    pushExp(2, 8'h00, "R12 no pulse");
    expCnt(16'hFFFF, "R3 two ticks");
    wrReg(3'd0, 8'h00);
    doTick;
    expCnt(16'hFFFF, "R3 run clear holds");
    wrReg(3'd0, 8'h01);
    doTick;
    // R6 overflow reload, R12 pulse, R11 irq
    pushExp(2, 8'h01, "R12 pulse on overflow");
    pushExp(1, 8'h01, "R11 irq from ovf flag");
    expCnt(16'h1234, "R6 reload on overflow");
    expRd(3'd0, 8'h81, "R6 ovf flag");
    doTick;
    pushExp(2, 8'h00, "R12 pulse one cycle");
    expRd(3'd0, 8'h81, "R10 flag sticks");
    expCnt(16'h1235, "R3 step");
    wrReg(3'd0, 8'h01);
    pushExp(1, 8'h00, "R10 sw clear");

    // R6 trigger reload
    wrCnt(16'h0100);
    wrReg(3'd0, 8'h09);
    trigPin = 1'b1; doTick;
    expCnt(16'h0101, "R6 no edge yet");
    trigPin = 1'b0; doTick;
    expCnt(16'h1234, "R6 trigger reload");
    expRd(3'd0, 8'h49, "R6 ext flag");
    pushExp(1, 8'h01, "R11 irq from ext flag");

    // R9 trigger ignored
    wrReg(3'd0, 8'h01);
    trigPin = 1'b1; doTick;
    trigPin = 1'b0; doTick;
    expCnt(16'h1236, "R9 no reload");
    expRd(3'd0, 8'h01, "R9 no ext flag");
    expRld(16'h1234, "R9 reload unchanged");

    // R5 capture
    wrReg(3'd0, 8'h0D);
    trigPin = 1'b1; doTick;
    trigPin = 1'b0; doTick;
    expRld(16'h1237, "R5 capture value");
    expCnt(16'h1238, "R5 count continues");
    expRd(3'd0, 8'h4D, "R5 ext flag");
    wrCnt(16'hFFFF);
    wrReg(3'd0, 8'h0D);
    doTick;
    expCnt(16'h0000, "R5 wrap to zero");
    expRd(3'd0, 8'h8D, "R5 ovf flag");
    expRld(16'h1237, "R5 no reload");

    // R7 up/down
    wrRld(16'h0005);
    wrReg(3'd1, 8'h01);
    expRd(3'd1, 8'h01, "R2 mode readback");
    wrReg(3'd0, 8'h01);
    wrCnt(16'h0006);
    trigPin = 1'b0;
    doTick;
    expCnt(16'h0005, "R7 count down");
    doTick;
    pushExp(2, 8'h01, "R12 pulse on underflow");
    expCnt(16'hFFFF, "R7 underflow loads ones");
    expRd(3'd0, 8'hC1, "R7 flags after underflow");
    wrReg(3'd0, 8'h01);
    trigPin = 1'b1;
    doTick;
    expCnt(16'h0005, "R7 up overflow reload");
    expRd(3'd0, 8'hC1, "R7 ext toggles to 1");
    wrReg(3'd0, 8'h41);
    pushExp(1, 8'h00, "R11 ext masked in up/down");
    wrCnt(16'hFFFF);
    doTick;
    expRd(3'd0, 8'h81, "R7 ext toggles to 0");
    wrReg(3'd1, 8'h00);

    // R8 baud generator
    wrReg(3'd0, 8'h15);
    wrRld(16'h00AA);
    wrCnt(16'hFFFF);
    doTick;
    pushExp(2, 8'h01, "R8 pulse in baud mode");
    pushExp(1, 8'h00, "R8 no irq");
    expCnt(16'h00AA, "R8 reload ignores capture select");
    expRd(3'd0, 8'h15, "R8 no flag");
    wrReg(3'd0, 8'h1D);
    trigPin = 1'b1; doTick;
    trigPin = 1'b0; doTick;
    expCnt(16'h00AC, "R8 trigger ignored");
    expRd(3'd0, 8'h1D, "R8 no ext flag");

    // R4 counter function
    wrReg(3'd0, 8'h03);
    wrCnt(16'h0000);
    cntPin = 1'b1; doTick; doTick;
    expCnt(16'h0000, "R4 high samples no count");
    cntPin = 1'b0; doTick;
    expCnt(16'h0001, "R4 falling edge counts");
    doTick;
    cntPin = 1'b1; doTick;
    cntPin = 1'b0; doTick;
    expCnt(16'h0002, "R4 second edge");

    // R13 write beats tick
    wrReg(3'd0, 8'h01);
    wrCnt(16'h0010);
    @(negedge clk);
    machineTick = 1'b1; wrEn = 1'b1; busAddr = 3'd2; wrData = 8'h55;
    @(negedge clk);
    machineTick = 1'b0; wrEn = 1'b0;
    expCnt(16'h0055, "R13 write wins");
    doTick;
    expCnt(16'h0056, "R13 resumes");

    finished = 1;
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule